// File: doc/BRIEF.md
# Planar Video Memory Write Unit

This block is the host write path of a video memory organised as four parallel bit planes. Each memory word holds one byte per plane. A host write carries an address and one, two or four data bytes. The unit turns each byte into a four-plane word using the active write mode. That process takes in a byte rotation, per-plane substitution of a constant colour, a logical operation against the 32-bit latch from the read unit, and a per-bit mask. The result is merged into the stored word so that only the enabled planes change.

On each accepted request the unit captures the host data, the latch and every configuration field. It then runs one read-merge-write cycle pair per byte through a simple synchronous memory port. The memory returns read data one cycle after the read strobe. While a request is in progress `busy` is high, and any new request is dropped.

Top module: `planar_wr_unit`

## Requirements
- R1: The host byte is rotated right by `cfg_rot` (0..7). Bits leaving bit 0 re-enter at bit 7, and a count of 0 leaves the byte unchanged.
- R2: Write mode 0 (`cfg_wmode`=0) places the rotated byte in every plane, except that a plane p with `cfg_esr[p]`=1 gets `cfg_sr[p]` copied to all 8 bits. Plane p is bits [8p+7:8p] of every 32-bit word.
- R3: Write mode 1 writes the captured latch unchanged into the enabled planes. The host byte, the logical operation and the bit mask have no effect.
- R4: Write mode 2 fills plane p with host bit p copied to all 8 bits, for p = 0..3. It does not rotate the byte. The result then goes through the logical operation and the bit mask.
- R5: Write mode 3 fills plane p with `cfg_sr[p]` copied to all 8 bits. The bit mask used is the rotated host byte ANDed with `cfg_bmask`.
- R6: `cfg_lop` selects the logical operation: 0 = pass the data, 1 = AND with the latch, 2 = OR with the latch, 3 = XOR with the latch. It applies in modes 0, 2 and 3.
- R7: The 8-bit mask is the same for every plane. A mask bit of 1 takes the processed bit, and a mask bit of 0 takes the latch bit, for every logical operation.
- R8: A plane p with `cfg_pwe[p]`=0 keeps its stored byte at the written address.
- R9: `wr_size` 0, 1 and 2 write 1, 2 and 4 bytes. Byte i of `wr_data` (bits [8i+7:8i]) goes to address `wr_addr`+i, lowest byte first. Each byte is processed on its own, using the same captured latch and configuration.
- R10: Each byte takes one read cycle followed by one write cycle at the same address, so a request keeps `busy` high for exactly 2 cycles per byte. A request made while `busy` is high is ignored.
- R11: After reset, `busy`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Host write request, taken when `busy` is low |
| wr_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wr_addr | input | 16 | Word address of the first byte |
| wr_data | input | 32 | Host data bytes, lowest first |
| latch_in | input | 32 | Four-plane latch from the read unit |
| cfg_wmode | input | 2 | Write mode 0..3 |
| cfg_rot | input | 3 | Right-rotate count |
| cfg_sr | input | 4 | Per-plane set/reset colour bits |
| cfg_esr | input | 4 | Per-plane set/reset enables (mode 0) |
| cfg_lop | input | 2 | Logical operation select |
| cfg_bmask | input | 8 | Bit mask shared by all planes |
| cfg_pwe | input | 4 | Per-plane write enables |
| busy | output | 1 | A request is in progress |
| mem_addr | output | 16 | Memory word address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Merged word to store |

## Verification
Directed writes use single-bit host patterns and rotate counts of 0 and 3, which shows whether the rotation goes right and wraps. Alternating set/reset enables separate substituted planes from rotated ones, and mode 1 is run with two unrelated host bytes to confirm the host byte has no effect. A half-filled bit mask is applied under each logical operation over a mixed latch, which separates the four operations from each other and from the masking. Random writes of every size, mode, mask and plane enable are then compared against a bench model, and an extra request injected during a four-byte write confirms that the request is dropped.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;
   typedef enum logic [1:0] {
      WM_SUBST  = 2'd0,
      WM_LATCH  = 2'd1,
      WM_FILL   = 2'd2,
      WM_MASKSR = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      LOP_PASS = 2'd0,
      LOP_AND  = 2'd1,
      LOP_OR   = 2'd2,
      LOP_XOR  = 2'd3
   } lop_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2
   } seq_e;
endpackage

// File: rtl/pw_rotate.sv
module pw_rotate #(
   parameter int W      = 8,
   parameter int BARREL = 1,
   localparam int CW    = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] cnt,
   output logic [W-1:0]  dout
);
   if ((W & (W - 1)) != 0 || W < 2) begin : g_bad_w
      $error("pw_rotate: W must be a power of two >= 2");
   end

   if (BARREL != 0) begin : g_barrel
      logic [W-1:0] stg [0:CW];
      assign stg[0] = din;
      for (genvar s = 0; s < CW; s++) begin : g_stage
         assign stg[s+1] = cnt[s] ? {stg[s][(1<<s)-1:0], stg[s][W-1:(1<<s)]} : stg[s];
      end
      assign dout = stg[CW];
   end else begin : g_double
      logic [2*W-1:0] dbl;
      assign dbl  = {din, din} >> cnt;
      assign dout = dbl[W-1:0];
   end

   // R1: a rotation only moves bits, never creates or drops them
   always_comb begin
      if (!$isunknown(din) && !$isunknown(cnt)) begin
         p_rot_keeps_bits_r1: assert ($countones(dout) == $countones(din));
      end
   end
endmodule

// File: rtl/pw_merge.sv
module pw_merge
   import planar_wr_pkg::*;
#(
   parameter int NPLANES = 4,
   parameter int PW      = 8,
   parameter int BARREL  = 1,
   localparam int CW     = $clog2(PW),
   localparam int DW     = NPLANES * PW
) (
   input  wmode_e             mode,
   input  lop_e               lop,
   input  logic [CW-1:0]      rot,
   input  logic [NPLANES-1:0] sr,
   input  logic [NPLANES-1:0] esr,
   input  logic [NPLANES-1:0] pwe,
   input  logic [PW-1:0]      bmask,
   input  logic [PW-1:0]      host,
   input  logic [DW-1:0]      latch,
   input  logic [DW-1:0]      stored,
   output logic [DW-1:0]      merged
);
   if (NPLANES > PW || NPLANES < 1) begin : g_bad_planes
      $error("pw_merge: NPLANES must be in 1..PW for host-bit fill");
   end

   logic [PW-1:0] rotd;

   pw_rotate #(.W(PW), .BARREL(BARREL)) u_rot (
      .din  (host),
      .cnt  (rot),
      .dout (rotd)
   );

   for (genvar p = 0; p < NPLANES; p++) begin : g_plane
      logic [PW-1:0] lat_p;
      logic [PW-1:0] dat_p;
      logic [PW-1:0] msk_p;
      logic [PW-1:0] res_p;

      assign lat_p = latch[p*PW +: PW];

      always_comb begin
         dat_p = rotd;
         msk_p = bmask;
         case (mode)
            WM_SUBST:  dat_p = esr[p] ? {PW{sr[p]}} : rotd;
            WM_LATCH: begin
               dat_p = lat_p;
               msk_p = '1;
            end
            WM_FILL:   dat_p = {PW{host[p]}};
            WM_MASKSR: begin
               dat_p = {PW{sr[p]}};
               msk_p = rotd & bmask;
            end
            default: ;
         endcase
         case (lop)
            LOP_PASS: res_p = (dat_p & msk_p) | (lat_p & ~msk_p);
            LOP_AND:  res_p = (dat_p | ~msk_p) & lat_p;
            LOP_OR:   res_p = (dat_p & msk_p) | lat_p;
            LOP_XOR:  res_p = (dat_p & msk_p) ^ lat_p;
            default:  res_p = lat_p;
         endcase
         if (mode == WM_LATCH) res_p = lat_p;
      end

      assign merged[p*PW +: PW] = pwe[p] ? res_p : stored[p*PW +: PW];

      // R7: every logical operation leaves masked-off bits equal to the latch
      always_comb begin
         if (!$isunknown({res_p, lat_p, msk_p})) begin
            p_mask_keeps_latch_r7: assert (((res_p ^ lat_p) & ~msk_p) == '0);
         end
      end
   end
endmodule

// File: rtl/pw_seq.sv
module pw_seq
   import planar_wr_pkg::*;
#(
   parameter int AW         = 16,
   parameter int HOST_BYTES = 4,
   localparam int IW        = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1,
   localparam int SW        = $clog2(IW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_req,
   input  logic [SW-1:0] wr_size,
   input  logic [AW-1:0] wr_addr,
   output logic          accept,
   output logic          busy,
   output logic          rd_en,
   output logic          wr_en,
   output logic [AW-1:0] mem_addr,
   output logic [IW-1:0] byte_idx
);
   if ((HOST_BYTES & (HOST_BYTES - 1)) != 0) begin : g_bad_hb
      $error("pw_seq: HOST_BYTES must be a power of two");
   end

   seq_e          st;
   logic [AW-1:0] cur_addr;
   logic [IW-1:0] idx;
   logic [IW-1:0] last_idx;
   logic [IW-1:0] req_last;
   int            span;

   always_comb begin
      span = 1 << wr_size;
      if (span > HOST_BYTES) span = HOST_BYTES;
      req_last = IW'(span - 1);
   end

   assign accept   = (st == SQ_IDLE) && wr_req;
   assign busy     = (st != SQ_IDLE);
   assign rd_en    = (st == SQ_READ);
   assign wr_en    = (st == SQ_WRITE);
   assign mem_addr = cur_addr;
   assign byte_idx = idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         cur_addr <= '0;
         idx      <= '0;
         last_idx <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (wr_req) begin
               st       <= SQ_READ;
               cur_addr <= wr_addr;
               idx      <= '0;
               last_idx <= req_last;
            end
            SQ_READ: st <= SQ_WRITE;
            SQ_WRITE: begin
               if (idx == last_idx) begin
                  st <= SQ_IDLE;
               end else begin
                  st       <= SQ_READ;
                  idx      <= idx + 1'b1;
                  cur_addr <= cur_addr + 1'b1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   p_wr_follows_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(rd_en) && $stable(mem_addr)));

   p_busy_starts_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_req));

   p_addr_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(wr_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_en, wr_en}));
endmodule

// File: rtl/planar_wr_unit.sv
module planar_wr_unit
   import planar_wr_pkg::*;
#(
   parameter int NPLANES    = 4,
   parameter int PW         = 8,
   parameter int AW         = 16,
   parameter int HOST_BYTES = 4,
   parameter int BARREL     = 1,
   localparam int DW        = NPLANES * PW,
   localparam int HW        = HOST_BYTES * PW,
   localparam int CW        = $clog2(PW),
   localparam int IW        = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1,
   localparam int SW        = $clog2(IW + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_req,
   input  logic [SW-1:0]      wr_size,
   input  logic [AW-1:0]      wr_addr,
   input  logic [HW-1:0]      wr_data,
   input  logic [DW-1:0]      latch_in,
   input  logic [1:0]         cfg_wmode,
   input  logic [CW-1:0]      cfg_rot,
   input  logic [NPLANES-1:0] cfg_sr,
   input  logic [NPLANES-1:0] cfg_esr,
   input  logic [1:0]         cfg_lop,
   input  logic [PW-1:0]      cfg_bmask,
   input  logic [NPLANES-1:0] cfg_pwe,
   output logic               busy,
   output logic [AW-1:0]      mem_addr,
   output logic               mem_rd_en,
   input  logic [DW-1:0]      mem_rdata,
   output logic               mem_wr_en,
   output logic [DW-1:0]      mem_wdata
);
   logic               accept;
   logic [IW-1:0]      byte_idx;
   logic [HW-1:0]      data_q;
   logic [DW-1:0]      latch_q;
   wmode_e             mode_q;
   lop_e               lop_q;
   logic [CW-1:0]      rot_q;
   logic [NPLANES-1:0] sr_q, esr_q, pwe_q;
   logic [PW-1:0]      bmask_q;
   logic [PW-1:0]      host_byte;

   pw_seq #(.AW(AW), .HOST_BYTES(HOST_BYTES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (wr_req),
      .wr_size  (wr_size),
      .wr_addr  (wr_addr),
      .accept   (accept),
      .busy     (busy),
      .rd_en    (mem_rd_en),
      .wr_en    (mem_wr_en),
      .mem_addr (mem_addr),
      .byte_idx (byte_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         latch_q <= '0;
         mode_q  <= WM_SUBST;
         lop_q   <= LOP_PASS;
         rot_q   <= '0;
         sr_q    <= '0;
         esr_q   <= '0;
         pwe_q   <= '0;
         bmask_q <= '0;
      end else if (accept) begin
         data_q  <= wr_data;
         latch_q <= latch_in;
         mode_q  <= wmode_e'(cfg_wmode);
         lop_q   <= lop_e'(cfg_lop);
         rot_q   <= cfg_rot;
         sr_q    <= cfg_sr;
         esr_q   <= cfg_esr;
         pwe_q   <= cfg_pwe;
         bmask_q <= cfg_bmask;
      end
   end

   assign host_byte = data_q[byte_idx*PW +: PW];

   pw_merge #(.NPLANES(NPLANES), .PW(PW), .BARREL(BARREL)) u_merge (
      .mode   (mode_q),
      .lop    (lop_q),
      .rot    (rot_q),
      .sr     (sr_q),
      .esr    (esr_q),
      .pwe    (pwe_q),
      .bmask  (bmask_q),
      .host   (host_byte),
      .latch  (latch_q),
      .stored (mem_rdata),
      .merged (mem_wdata)
   );

   for (genvar p = 0; p < NPLANES; p++) begin : g_chk
      p_plane_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_wr_en && !pwe_q[p]) |-> (mem_wdata[p*PW +: PW] == mem_rdata[p*PW +: PW]));

      p_latch_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_wr_en && pwe_q[p] && mode_q == WM_LATCH)
            |-> (mem_wdata[p*PW +: PW] == latch_q[p*PW +: PW]));
   end
endmodule

// File: tb/planar_wr_unit_test.sv
module planar_wr_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0;
   logic [1:0]  wr_size = '0;
   logic [15:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] latch_in = '0;
   logic [1:0]  cfg_wmode = '0;
   logic [2:0]  cfg_rot = '0;
   logic [3:0]  cfg_sr = '0;
   logic [3:0]  cfg_esr = '0;
   logic [1:0]  cfg_lop = '0;
   logic [7:0]  cfg_bmask = 8'hFF;
   logic [3:0]  cfg_pwe = 4'hF;
   logic        busy;
   logic [15:0] mem_addr;
   logic        mem_rd_en;
   logic [31:0] mem_rdata = '0;
   logic        mem_wr_en;
   logic [31:0] mem_wdata;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] mem    [0:255];
   logic [31:0] shadow [0:255];

   always #10 clk = ~clk;

   planar_wr_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_size(wr_size),
      .wr_addr(wr_addr), .wr_data(wr_data), .latch_in(latch_in),
      .cfg_wmode(cfg_wmode), .cfg_rot(cfg_rot), .cfg_sr(cfg_sr),
      .cfg_esr(cfg_esr), .cfg_lop(cfg_lop), .cfg_bmask(cfg_bmask),
      .cfg_pwe(cfg_pwe), .busy(busy), .mem_addr(mem_addr),
      .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
      .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
   );

   function automatic logic [31:0] initv(input int i);
      return (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= initv(i);
      end else begin
         if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
         if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
      end
   end

   function automatic logic [31:0] model(input logic [1:0] md, input logic [2:0] rt,
      input logic [3:0] sr, input logic [3:0] esr, input logic [1:0] lp,
      input logic [7:0] bm, input logic [3:0] pw, input logic [31:0] lat,
      input logic [7:0] h, input logic [31:0] old);
      logic [7:0]  r;
      logic [31:0] o;
      logic d, m, l, res;
      for (int i = 0; i < 8; i++) r[i] = h[(i + int'(rt)) % 8];
      for (int p = 0; p < 4; p++) begin
         for (int b = 0; b < 8; b++) begin
            l = lat[8*p+b];
            d = 1'b0; m = bm[b];
            case (md)
               2'd0: d = esr[p] ? sr[p] : r[b];
               2'd2: d = h[p];
               2'd3: begin d = sr[p]; m = r[b] & bm[b]; end
               default: ;
            endcase
            case (lp)
               2'd0: res = m ? d : l;
               2'd1: res = m ? (d & l) : l;
               2'd2: res = m ? (d | l) : l;
               default: res = m ? (d ^ l) : l;
            endcase
            if (md == 2'd1) res = l;
            o[8*p+b] = pw[p] ? res : old[8*p+b];
         end
      end
      return o;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("[TB] FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] dat,
                         input bit inject, input string tag);
      int nb, cnt, nw;
      bit order_ok;
      logic [7:0] ix;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      for (int i = 0; i < nb; i++) begin
         ix = a[7:0] + 8'(i);
         shadow[ix] = model(cfg_wmode, cfg_rot, cfg_sr, cfg_esr, cfg_lop, cfg_bmask,
                            cfg_pwe, latch_in, dat[8*i +: 8], shadow[ix]);
      end
      @(negedge clk);
      wr_req = 1'b1; wr_size = sz; wr_addr = a; wr_data = dat;
      @(negedge clk);
      wr_req = 1'b0;
      cnt = 0; nw = 0; order_ok = 1'b1;
      while (busy && cnt < 50) begin
         if (mem_rd_en && mem_wr_en) order_ok = 1'b0;
         if (mem_wr_en) begin
            if (mem_addr != a + 16'(nw)) order_ok = 1'b0;
            nw++;
         end
         cnt++;
         if (inject && cnt == 2) begin
            wr_req = 1'b1; wr_addr = 16'd200; wr_data = 32'hFFFF_FFFF;
         end else begin
            wr_req = 1'b0;
         end
         @(negedge clk);
      end
      wr_req = 1'b0;
      chk(cnt == 2*nb, "R10 busy cycles", 32'(cnt), 32'(2*nb));
      chk(order_ok && nw == nb, "R9 byte write order", 32'(nw), 32'(nb));
      for (int i = 0; i < nb; i++) begin
         ix = a[7:0] + 8'(i);
         chk(mem[ix] === shadow[ix], tag, mem[ix], shadow[ix]);
      end
   endtask

   initial begin
      #(20 * 150000);
      n_tests++; n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) shadow[i] = initv(i);
      repeat (4) @(negedge clk);
      // R11: idle outputs while and right after reset
      chk(!busy && !mem_rd_en && !mem_wr_en, "R11 reset state",
          {29'd0, busy, mem_rd_en, mem_wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_rd_en && !mem_wr_en, "R11 idle after reset",
          {29'd0, busy, mem_rd_en, mem_wr_en}, 32'd0);

      // R1: count 0 keeps the byte
      cfg_wmode = 2'd0; cfg_rot = 3'd0; cfg_esr = 4'h0; cfg_lop = 2'd0;
      cfg_bmask = 8'hFF; cfg_pwe = 4'hF;
      run_op(2'd0, 16'd10, 32'h0000_005A, 1'b0, "R1 rot0 model");
      chk(mem[10] == 32'h5A5A_5A5A, "R1 rot0 literal", mem[10], 32'h5A5A_5A5A);
      // R1: rotate right by 3 wraps bit 0 to bit 5
      cfg_rot = 3'd3;
      run_op(2'd0, 16'd11, 32'h0000_0001, 1'b0, "R1 rot3 model");
      chk(mem[11] == 32'h2020_2020, "R1 rot3 literal", mem[11], 32'h2020_2020);
      // R2: set/reset substitution on planes 0 and 2
      cfg_rot = 3'd0; cfg_esr = 4'b0101; cfg_sr = 4'b0001;
      run_op(2'd0, 16'd12, 32'h0000_005A, 1'b0, "R2 model");
      chk(mem[12] == 32'h5A00_5AFF, "R2 literal", mem[12], 32'h5A00_5AFF);
      // R3: latch copy, two different host bytes
      cfg_wmode = 2'd1; latch_in = 32'h1234_5678; cfg_lop = 2'd3; cfg_bmask = 8'h0F;
      run_op(2'd0, 16'd13, 32'h0000_00FF, 1'b0, "R3 host FF");
      run_op(2'd0, 16'd14, 32'h0000_0000, 1'b0, "R3 host 00");
      chk(mem[13] == mem[14] && mem[13] == 32'h1234_5678, "R3 host ignored", mem[13], 32'h1234_5678);
      // R4: host bits replicated into planes
      cfg_wmode = 2'd2; cfg_lop = 2'd0; cfg_bmask = 8'hFF; cfg_rot = 3'd5;
      run_op(2'd0, 16'd15, 32'h0000_00A6, 1'b0, "R4 model");
      chk(mem[15] == 32'h00FF_FF00, "R4 literal", mem[15], 32'h00FF_FF00);
      // R5: set/reset colour with rotated-host mask
      cfg_wmode = 2'd3; cfg_rot = 3'd0; cfg_sr = 4'hF; cfg_bmask = 8'h3C; latch_in = 32'h0;
      run_op(2'd0, 16'd16, 32'h0000_000F, 1'b0, "R5 model");
      chk(mem[16] == 32'h0C0C_0C0C, "R5 literal", mem[16], 32'h0C0C_0C0C);
      // R6 and R7: every logical operation with half mask
      cfg_wmode = 2'd0; cfg_esr = 4'h0; cfg_bmask = 8'hF0; latch_in = 32'hC3A5_5A3C;
      for (int lp = 0; lp < 4; lp++) begin
         cfg_lop = 2'(lp);
         run_op(2'd0, 16'(20 + lp), 32'h0000_00CC, 1'b0, "R6 R7 logical op");
      end
      // R8: planes 1 and 3 disabled
      cfg_lop = 2'd0; cfg_bmask = 8'hFF; cfg_pwe = 4'b0101;
      run_op(2'd0, 16'd30, 32'h0000_0000, 1'b0, "R8 model");
      chk(mem[30][15:8] == initv(30)[15:8] && mem[30][31:24] == initv(30)[31:24],
          "R8 disabled planes kept", mem[30], initv(30));
      // R9: two and four byte writes
      cfg_pwe = 4'hF;
      run_op(2'd1, 16'd40, 32'h0000_BEEF, 1'b0, "R9 two bytes");
      run_op(2'd2, 16'd44, 32'h0102_0408, 1'b0, "R9 four bytes");
      // R10: request during busy is dropped
      run_op(2'd2, 16'd50, 32'h7766_5544, 1'b1, "R10 inject op");
      chk(mem[200] === shadow[200], "R10 dropped request", mem[200], shadow[200]);

      // random mix
      for (int k = 0; k < 400; k++) begin
         logic [1:0] sz;
         cfg_wmode = 2'($urandom_range(0, 3));
         cfg_rot   = 3'($urandom_range(0, 7));
         cfg_sr    = 4'($urandom);
         cfg_esr   = 4'($urandom);
         cfg_lop   = 2'($urandom_range(0, 3));
         cfg_bmask = 8'($urandom);
         cfg_pwe   = 4'($urandom);
         latch_in  = $urandom;
         sz = 2'($urandom_range(0, 2));
         case (cfg_wmode)
            2'd0: run_op(sz, 16'($urandom_range(60, 190)), $urandom, 1'b0, "R2 R6 random");
            2'd1: run_op(sz, 16'($urandom_range(60, 190)), $urandom, 1'b0, "R3 R8 random");
            2'd2: run_op(sz, 16'($urandom_range(60, 190)), $urandom, 1'b0, "R4 R7 random");
            default: run_op(sz, 16'($urandom_range(60, 190)), $urandom, 1'b0, "R5 R1 random");
         endcase
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule